// File: doc/BRIEF.md
# Transmit Frame Abort Sequencer

This block sits on the nibble-wide transmit path of an Ethernet MAC and supervises each outgoing frame for three fatal conditions: the transmit FIFO running dry, a collision that arrives after the slot time, and the retry logic giving up. While no fault is present it forwards the MAC's nibble stream to the line with one register stage. When a fault is accepted it stops the frame. After an underrun it first appends a 32-bit trailer built from the inverted running CRC, so the far end is certain to discard the frame.

After any abort the sequencer walks the descriptor side. It closes every descriptor that still belongs to the aborted frame, then pulses a request to advance to the next frame. It then waits for the MAC to drop the aborted frame's active flag, and forwards the next frame without software help. A collision that comes early enough to be normal is handed to the retry logic instead.

Each abort cause latches a sticky event bit, cleared by writing one. Each event bit drives an interrupt line through its own mask bit.

Top module: `tx_abort_seq`

## Requirements
- R1: In the forwarding state with no abort accepted, a cycle with `tx_act_i` high makes `tx_en_o` high and `tx_nib_o` equal to `tx_nib_i` on the next cycle. A cycle with `tx_act_i` low gives `tx_en_o` low and `tx_nib_o` zero on the next cycle.
- R2: An accepted underrun makes `tx_en_o` high for exactly 8 cycles, starting the cycle after the strobe. Nibble k of this trailer (k = 0..7) is bits [4k+3:4k] of the bitwise inverse of `crc_i` as sampled in the strobe cycle. `tx_en_o` is low after the trailer.
- R3: Nibbles are numbered from 0 at the first active cycle of a frame, preamble included. A collision (`col_i` with `tx_act_i`) during nibble 128 or later, which is past 512 bit times, aborts the frame, sets event bit 2, and drives `tx_en_o` low on the next cycle. A collision during nibble 127 or earlier gives a `col_retry_o` pulse in the same cycle, and the frame continues.
- R4: A `retry_exh_i` strobe in the forwarding state aborts the frame, sets event bit 1, and drives `tx_en_o` low on the next cycle. An accepted underrun sets event bit 0.
- R5: After an abort, and after the trailer in the underrun case, `dsc_close_o` is high in every cycle in which `dsc_more_i` is high. The first cycle with `dsc_more_i` low is followed by a single-cycle `dsc_next_o` pulse.
- R6: After `dsc_next_o`, the sequencer ignores the rest of the aborted frame until `tx_act_i` is low. It then forwards the next frame per R1 without any other input.
- R7: If several causes are accepted in one cycle, only one abort runs and only one event bit is set. Underrun wins over late collision, and late collision wins over retry limit.
- R8: Event bits are sticky and clear when the matching `ev_clr_i` bit is 1. An event set in the same cycle as its clear leaves the bit set.
- R9: `irq_o[i]` is high exactly when event bit i and `irq_mask_i[i]` are both high.
- R10: During and right after reset, `tx_en_o`, `tx_nib_o`, `ev_o`, `irq_o`, `dsc_close_o`, `dsc_next_o` and `col_retry_o` are all zero.
- R11: The nibble count restarts at every rising edge of `tx_act_i` and saturates once past the slot. A long earlier frame does not make an early collision in the next frame late, and a collision long past the slot is still late.
- R12: Underrun, collision and retry strobes that arrive outside the forwarding state are ignored. They change neither the event bits nor the output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_nib_i | input | 4 | Transmit nibble from the MAC |
| tx_act_i | input | 1 | Frame active flag from the MAC |
| underrun_i | input | 1 | FIFO underrun strobe |
| col_i | input | 1 | Collision indication |
| retry_exh_i | input | 1 | Retry limit exhausted strobe |
| crc_i | input | 32 | Running CRC of the nibbles sent so far |
| dsc_more_i | input | 1 | Current descriptor still belongs to the aborted frame |
| ev_clr_i | input | 3 | Write-one-to-clear for the event bits |
| irq_mask_i | input | 3 | Interrupt mask, one bit per event |
| tx_nib_o | output | 4 | Nibble toward the line |
| tx_en_o | output | 1 | Line enable |
| col_retry_o | output | 1 | Early collision handed to the retry logic |
| dsc_close_o | output | 1 | Close the current descriptor as flushed |
| dsc_next_o | output | 1 | Advance to the next frame's descriptor |
| ev_o | output | 3 | Sticky events: bit 0 underrun, bit 1 retry limit, bit 2 late collision |
| irq_o | output | 3 | Masked interrupt lines |

## Verification
Two coincidences matter most. The first is two or three abort causes landing in one cycle: the bench raises an underrun, a late collision and a retry strobe on the same nibble, and then a late collision together with a retry strobe. A behavioural model judges the result, and only the winning event bit and only its output sequence may appear. The second is an event being set in the same cycle that software clears it: the bench holds the clear mask at all ones across an abort, and the model expects the new bit to survive. Strobes sent during the trailer and during the flush round out the checks of what must be ignored.

// File: rtl/tx_abort_pkg.sv
package tx_abort_pkg;

  typedef enum logic [2:0] {
    ST_FWD   = 3'd0,
    ST_JAM   = 3'd1,
    ST_FLUSH = 3'd2,
    ST_NEXT  = 3'd3,
    ST_WAIT  = 3'd4
  } seq_st_e;

  // event bit positions, software decodes these
  localparam int unsigned EV_UN = 0;
  localparam int unsigned EV_RL = 1;
  localparam int unsigned EV_LC = 2;
  localparam int unsigned EV_N  = 3;

  typedef struct packed {
    logic un;
    logic lc;
    logic rl;
  } cause_t;

  function automatic logic [EV_N-1:0] cause_to_ev(input cause_t c);
    logic [EV_N-1:0] v;
    v        = '0;
    v[EV_UN] = c.un;
    v[EV_RL] = c.rl;
    v[EV_LC] = c.lc;
    return v;
  endfunction

endpackage

// File: rtl/tas_slot_timer.sv
module tas_slot_timer #(
  parameter int unsigned NIB_W     = 4,
  parameter int unsigned SLOT_BITS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic col_i,
  output logic late_o
);
  localparam int unsigned SLOT_NIBS = SLOT_BITS / NIB_W;
  localparam int unsigned SAT       = SLOT_NIBS + 1;
  localparam int unsigned CNT_W     = $clog2(SAT + 1);

  logic             act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             frm_start;
  logic [CNT_W-1:0] nib_idx;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v >= CNT_W'(SAT)) ? CNT_W'(SAT) : v + 1'b1;
  endfunction

  // nibble idx covers bits 4*idx .. 4*idx+3; late once more than SLOT_BITS elapsed
  function automatic logic is_late(input logic [CNT_W-1:0] idx);
    return idx >= CNT_W'(SLOT_NIBS);
  endfunction

  assign frm_start = act_i & ~act_q;
  assign nib_idx   = frm_start ? '0 : cnt_q;
  assign late_o    = col_i & act_i & is_late(nib_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_i;
      if (act_i) cnt_q <= frm_start ? CNT_W'(1) : sat_inc(cnt_q);
    end
  end

  a_r11_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(SAT));

endmodule

// File: rtl/tas_cause_arb.sv
module tas_cause_arb
  import tx_abort_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en_i,
  input  logic   un_i,
  input  logic   lc_i,
  input  logic   rl_i,
  output cause_t win_o,
  output logic   any_o
);
  always_comb begin
    win_o = '0;
    if (en_i) begin
      if (un_i)      win_o.un = 1'b1;
      else if (lc_i) win_o.lc = 1'b1;
      else if (rl_i) win_o.rl = 1'b1;
    end
  end

  assign any_o = win_o.un | win_o.lc | win_o.rl;

  a_r7_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_o));

  a_r7_underrun_first: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && un_i) |-> win_o.un);

endmodule

// File: rtl/tas_event_regs.sv
module tas_event_regs #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] ev_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] ev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= (ev_q & ~clr_i) | set_i;
  end

  assign ev_o  = ev_q;
  assign irq_o = ev_q & mask_i;

  a_r8_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((ev_q & $past(set_i)) == $past(set_i)));

  a_r8_hold_no_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0) |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

endmodule

// File: rtl/tas_jam_gen.sv
module tas_jam_gen #(
  parameter int unsigned CRC_W = 32,
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CRC_W-1:0] crc_i,
  input  logic             step_i,
  output logic [NIB_W-1:0] first_o,
  output logic [NIB_W-1:0] nib_o,
  output logic             done_o
);
  localparam int unsigned JAM_NIBS = CRC_W / NIB_W;
  localparam int unsigned K_W      = $clog2(JAM_NIBS + 1);

  logic [CRC_W-1:0] inv_q;
  logic [K_W-1:0]   k_q;

  function automatic logic [NIB_W-1:0] pick(input logic [CRC_W-1:0] v,
                                            input logic [K_W-1:0] k);
    logic [NIB_W-1:0] r;
    r = '0;
    for (int i = 0; i < JAM_NIBS; i++)
      if (k == K_W'(i)) r = v[i*NIB_W +: NIB_W];
    return r;
  endfunction

  assign first_o = pick(~crc_i, '0);
  assign nib_o   = pick(inv_q, k_q);
  assign done_o  = (k_q == K_W'(JAM_NIBS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_q <= '0;
      k_q   <= K_W'(JAM_NIBS);
    end else if (load_i) begin
      inv_q <= ~crc_i;
      k_q   <= K_W'(1);
    end else if (step_i && !done_o) begin
      k_q <= k_q + 1'b1;
    end
  end

  a_r2_index_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    k_q <= K_W'(JAM_NIBS));

endmodule

// File: rtl/tx_abort_seq.sv
module tx_abort_seq
  import tx_abort_pkg::*;
#(
  parameter int unsigned NIB_W     = 4,
  parameter int unsigned CRC_W     = 32,
  parameter int unsigned SLOT_BITS = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] tx_nib_i,
  input  logic             tx_act_i,
  input  logic             underrun_i,
  input  logic             col_i,
  input  logic             retry_exh_i,
  input  logic [CRC_W-1:0] crc_i,
  input  logic             dsc_more_i,
  input  logic [EV_N-1:0]  ev_clr_i,
  input  logic [EV_N-1:0]  irq_mask_i,
  output logic [NIB_W-1:0] tx_nib_o,
  output logic             tx_en_o,
  output logic             col_retry_o,
  output logic             dsc_close_o,
  output logic             dsc_next_o,
  output logic [EV_N-1:0]  ev_o,
  output logic [EV_N-1:0]  irq_o
);
  seq_st_e          st_q;
  logic             in_fwd;
  logic             late_hit;
  logic             abort_go;
  cause_t           win;
  logic [EV_N-1:0]  ev_set;
  logic [NIB_W-1:0] jam_first;
  logic [NIB_W-1:0] jam_nib;
  logic             jam_done;
  logic             jam_step;

  assign in_fwd = (st_q == ST_FWD);

  tas_slot_timer #(.NIB_W(NIB_W), .SLOT_BITS(SLOT_BITS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .act_i  (tx_act_i),
    .col_i  (col_i),
    .late_o (late_hit)
  );

  tas_cause_arb u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (in_fwd),
    .un_i  (underrun_i & tx_act_i),
    .lc_i  (late_hit),
    .rl_i  (retry_exh_i),
    .win_o (win),
    .any_o (abort_go)
  );

  assign ev_set = cause_to_ev(win);

  tas_event_regs #(.N(EV_N)) u_ev (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ev_set),
    .clr_i  (ev_clr_i),
    .mask_i (irq_mask_i),
    .ev_o   (ev_o),
    .irq_o  (irq_o)
  );

  assign jam_step = (st_q == ST_JAM);

  tas_jam_gen #(.CRC_W(CRC_W), .NIB_W(NIB_W)) u_jam (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (win.un),
    .crc_i   (crc_i),
    .step_i  (jam_step),
    .first_o (jam_first),
    .nib_o   (jam_nib),
    .done_o  (jam_done)
  );

  // early collision goes to the retry logic unless an abort takes the cycle
  assign col_retry_o = in_fwd & tx_act_i & col_i & ~late_hit & ~underrun_i & ~retry_exh_i;
  assign dsc_close_o = (st_q == ST_FLUSH) & dsc_more_i;
  assign dsc_next_o  = (st_q == ST_NEXT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_FWD;
      tx_en_o  <= 1'b0;
      tx_nib_o <= '0;
    end else begin
      unique case (st_q)
        ST_FWD: begin
          if (win.un) begin
            st_q     <= ST_JAM;
            tx_en_o  <= 1'b1;
            tx_nib_o <= jam_first;
          end else if (abort_go) begin
            st_q     <= ST_FLUSH;
            tx_en_o  <= 1'b0;
            tx_nib_o <= '0;
          end else begin
            tx_en_o  <= tx_act_i;
            tx_nib_o <= tx_act_i ? tx_nib_i : '0;
          end
        end
        ST_JAM: begin
          if (!jam_done) begin
            tx_en_o  <= 1'b1;
            tx_nib_o <= jam_nib;
          end else begin
            st_q     <= ST_FLUSH;
            tx_en_o  <= 1'b0;
            tx_nib_o <= '0;
          end
        end
        ST_FLUSH: if (!dsc_more_i) st_q <= ST_NEXT;
        ST_NEXT:  st_q <= tx_act_i ? ST_WAIT : ST_FWD;
        ST_WAIT:  if (!tx_act_i) st_q <= ST_FWD;
        default:  st_q <= ST_FWD;
      endcase
    end
  end

  a_r2_jam_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_JAM) |-> tx_en_o);

  a_r4_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (win.rl || win.lc) |=> !tx_en_o);

  a_r5_next_single: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_next_o |=> !dsc_next_o);

  a_r6_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> !tx_en_o);

  a_r12_no_cause_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !in_fwd |-> (ev_set == '0));

endmodule

// File: tb/sim_tx_abort_seq.sv
module sim_tx_abort_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  nib = '0;
  logic        act = 1'b0, un = 1'b0, col = 1'b0, rex = 1'b0;
  logic [31:0] crc = '0;
  logic [2:0]  clr = '0, mask = '0;
  int          rem = 0;
  logic        more;
  logic [3:0]  o_nib;
  logic        o_en, o_cr, o_close, o_next;
  logic [2:0]  o_ev, o_irq;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign more = (rem != 0);

  tx_abort_seq u0 (
    .clk(clk), .rst_n(rst_n), .tx_nib_i(nib), .tx_act_i(act), .underrun_i(un),
    .col_i(col), .retry_exh_i(rex), .crc_i(crc), .dsc_more_i(more),
    .ev_clr_i(clr), .irq_mask_i(mask), .tx_nib_o(o_nib), .tx_en_o(o_en),
    .col_retry_o(o_cr), .dsc_close_o(o_close), .dsc_next_o(o_next),
    .ev_o(o_ev), .irq_o(o_irq)
  );

  // descriptor side: each close consumes one remaining descriptor
  always @(posedge clk) if (o_close && rem > 0) rem <= rem - 1;

  // behavioural reference model
  int          m_st = 0;        // 0 fwd,1 trailer,2 flush,3 next,4 wait
  int          m_cnt = 0, m_jk = 0;
  bit          m_pact = 0, m_en = 0;
  int          m_nib = 0;
  logic [31:0] m_inv = '0;
  logic [2:0]  m_ev = '0;

  function automatic bit m_late();
    int idx;
    idx = (act && !m_pact) ? 0 : m_cnt;
    return col && act && idx >= 128;
  endfunction

  function automatic bit m_cr();
    return m_st == 0 && act && col && !m_late() && !un && !rex;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_jk = 0; m_pact = 0; m_en = 0; m_nib = 0; m_ev = '0;
    end else begin
      logic [2:0] set;
      bit lt;
      set = '0;
      lt  = m_late();
      case (m_st)
        0: begin
          if (act && un) begin
            set = 3'b001; m_inv = ~crc; m_en = 1; m_nib = int'(m_inv[3:0]); m_jk = 1; m_st = 1;
          end else if (lt) begin
            set = 3'b100; m_en = 0; m_nib = 0; m_st = 2;
          end else if (rex) begin
            set = 3'b010; m_en = 0; m_nib = 0; m_st = 2;
          end else begin
            m_en = act; m_nib = act ? int'(nib) : 0;
          end
        end
        1: begin
          if (m_jk < 8) begin
            m_nib = int'((m_inv >> (4 * m_jk)) & 32'hF); m_en = 1; m_jk++;
          end else begin
            m_en = 0; m_nib = 0; m_st = 2;
          end
        end
        2: if (!more) m_st = 3;
        3: m_st = act ? 4 : 0;
        default: if (!act) m_st = 0;
      endcase
      if (act) m_cnt = (act && !m_pact) ? 1 : (m_cnt < 129 ? m_cnt + 1 : 129);
      m_pact = act;
      m_ev = (m_ev & ~clr) | set;
    end
  end

  task automatic chk(input string tag, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("R1 R2 R6 R12 tx_en", int'(o_en), int'(m_en));
      chk("R1 R2 R6 R12 tx_nib", int'(o_nib), m_nib);
      chk("R3 R11 col_retry", int'(o_cr), int'(rst_n && m_cr()));
      chk("R5 dsc_close", int'(o_close), int'(rst_n && m_st == 2 && more));
      chk("R5 R6 dsc_next", int'(o_next), int'(rst_n && m_st == 3));
      chk("R3 R4 R7 R8 R12 events", int'(o_ev), int'(m_ev));
      chk("R9 irq", int'(o_irq), int'(m_ev & mask));
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic frame(input int len, input int un_at, input int col_at, input int rex_at,
                       input int col2_at, input int ndsc, input int gap);
    rem = ndsc;
    for (int i = 0; i < len; i++) begin
      act = 1'b1;
      nib = 4'(i) ^ 4'h5;
      crc = 32'hC0DE_1234 + 32'(i * 97);
      un  = (i == un_at);
      col = (i == col_at) || (i == col2_at);
      rex = (i == rex_at);
      cyc();
    end
    act = 0; un = 0; col = 0; rex = 0; nib = '0;
    for (int g = 0; g < gap; g++) cyc();
  endtask

  initial begin
    cyc(); cyc();
    // R10: reset values at the ports
    chk("R10 reset tx_en", int'(o_en), 0);
    chk("R10 reset events", int'(o_ev), 0);
    chk("R10 reset irq", int'(o_irq), 0);
    rst_n = 1'b1;
    cyc();
    chk("R10 after release dsc_next", int'(o_next), 0);
    mask = 3'b111;
    frame(20, -1, -1, -1, -1, 0, 4);               // R1 clean frame
    frame(30, 12, -1, -1, -1, 2, 20);              // R2 R5 underrun trailer, two closes
    clr = 3'b111; cyc(); clr = '0; cyc();          // R8 clear
    frame(140, -1, 130, -1, -1, 1, 20);            // R3 late collision
    frame(140, -1, 127, -1, -1, 0, 4);             // R3 early collision retried
    frame(140, -1, 128, -1, -1, 0, 20);            // R3 boundary late
    frame(10, -1, -1, 5, -1, 3, 20);               // R4 retry exhausted
    mask = 3'b010;
    frame(10, -1, -1, -1, -1, 0, 4);               // R9 masked view
    clr = 3'b111; cyc(); clr = '0; mask = 3'b101;
    frame(150, 135, 135, 135, -1, 1, 20);          // R7 all three at once
    frame(150, -1, 140, 140, -1, 1, 20);           // R7 late beats retry
    clr = 3'b111;
    frame(10, -1, -1, 4, -1, 0, 20);               // R8 set beats clear
    clr = '0;
    frame(300, -1, 290, -1, -1, 0, 20);            // R11 saturated count still late
    frame(128, -1, 127, -1, -1, 0, 4);             // R11 fresh count after long frame
    clr = 3'b111; cyc(); clr = '0;
    frame(40, 10, 14, 16, -1, 2, 20);              // R12 strobes during trailer ignored
    frame(200, -1, -1, 3, 150, 0, 4);              // R6 R12 aborted frame keeps going, ignored
    frame(25, -1, -1, -1, -1, 0, 6);               // R6 next frame forwarded
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule